// File: doc/BRIEF.md
# Write Precompensation Early/Late Detector

This block sits in the write path of a disk channel, after the run-length encoder. It takes the serial code stream one bit per code period and decides, for every 1 bit, whether the write pulse for that bit should be moved in time. It looks at the code bits two positions before and two positions after the bit it is judging. When only one side holds a 1, the bit is flagged: EARLY if the neighbour written first is the 1, LATE if the one written later is the 1. A symmetric neighbourhood, or no neighbours at all, gives no shift.

The bit under judgement leaves the block on `code_o` together with its two flags, so an external delay network can use all three signals for one code period. A bypass input forces both flags low without disturbing the code path. The shift register that forms the window advances only on cycles with `code_en_i` high, so the block can run from a fast system clock with a code-rate enable.

Top module: `precomp_flagger`

## Requirements
- R1: While `rst_ni` is low, and after it rises until new bits shift in, the window holds zeros, so `code_o`, `early_o` and `late_o` are all low.
- R2: The window advances only on a rising clock edge with `code_en_i` high. `code_o` is the `code_bit_i` value sampled at the third most recent enabled edge. On a cycle with `code_en_i` low, all outputs keep their values.
- R3: When `code_o` is 0, `early_o` and `late_o` are both low.
- R4: When `code_o` is 1 and the bits two positions before and two positions after it are both 0, both flags are low.
- R5: When `code_o` is 1 and both of those neighbours are 1, both flags are low.
- R6: When `code_o` is 1 and only the earlier neighbour is 1, `early_o` is high and `late_o` is low. The earlier neighbour is the bit sampled two enabled edges before the target.
- R7: When `code_o` is 1 and only the later neighbour is 1, `late_o` is high and `early_o` is low. The later neighbour is the bit sampled two enabled edges after the target.
- R8: While `bypass_i` is high, both flags are low in the same cycle. `code_o` and the window contents are not affected by `bypass_i`.
- R9: `early_o` and `late_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_en_i | input | 1 | Code-rate enable; window shifts when high |
| code_bit_i | input | 1 | Serial code bit, in write order |
| bypass_i | input | 1 | Forces both flags low |
| code_o | output | 1 | Delayed code bit (the target bit) |
| early_o | output | 1 | Target needs early precompensation |
| late_o | output | 1 | Target needs late precompensation |

## Verification
The hardest state to reach from the ports is a window that already holds a specific five-bit pattern while `code_en_i` stalls or `bypass_i` toggles. The bench has to confirm that the flags and `code_o` freeze through the stall, and that releasing the bypass brings back the flag the frozen pattern calls for. Directed sequences shift in each neighbour pattern around a 1 target, then hold the enable low and toggle the bypass. Random stimulus with sparse enables and occasional bypass then mixes these situations with arbitrary code streams. A bench shift-register model predicts every cycle.

// File: rtl/precomp_pkg.sv
package precomp_pkg;
  typedef enum logic [1:0] {
    SHIFT_NONE  = 2'd0,
    SHIFT_EARLY = 2'd1,
    SHIFT_LATE  = 2'd2
  } shift_e;
endpackage

// File: rtl/precomp_window.sv
module precomp_window #(
  parameter int unsigned SPAN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic earlier_o,
  output logic target_o,
  output logic later_o
);
  localparam int unsigned WIN_W = 2 * SPAN + 1;

  // stage[0] holds the newest bit, stage[WIN_W-1] the oldest
  logic [WIN_W-1:0] stage_q;

  for (genvar g = 0; g < WIN_W; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   stage_q[g] <= 1'b0;
        else if (en_i) stage_q[g] <= bit_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   stage_q[g] <= 1'b0;
        else if (en_i) stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign earlier_o = stage_q[WIN_W-1];
  assign target_o  = stage_q[SPAN];
  assign later_o   = stage_q[0];

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(stage_q));
endmodule

// File: rtl/precomp_classify.sv
module precomp_classify
  import precomp_pkg::*;
(
  input  logic   earlier_i,
  input  logic   target_i,
  input  logic   later_i,
  input  logic   bypass_i,
  output shift_e shift_o
);
  always_comb begin
    shift_o = SHIFT_NONE;
    if (!bypass_i && target_i) begin
      unique case ({earlier_i, later_i})
        2'b10:   shift_o = SHIFT_EARLY;
        2'b01:   shift_o = SHIFT_LATE;
        default: shift_o = SHIFT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/precomp_flagger.sv
module precomp_flagger
  import precomp_pkg::*;
#(
  parameter int unsigned SPAN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic code_en_i,
  input  logic code_bit_i,
  input  logic bypass_i,
  output logic code_o,
  output logic early_o,
  output logic late_o
);
  logic   tap_earlier, tap_target, tap_later;
  shift_e shift;

  precomp_window #(.SPAN(SPAN)) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (code_en_i),
    .bit_i     (code_bit_i),
    .earlier_o (tap_earlier),
    .target_o  (tap_target),
    .later_o   (tap_later)
  );

  precomp_classify u_classify (
    .earlier_i (tap_earlier),
    .target_i  (tap_target),
    .later_i   (tap_later),
    .bypass_i  (bypass_i),
    .shift_o   (shift)
  );

  assign code_o  = tap_target;
  assign early_o = (shift == SHIFT_EARLY);
  assign late_o  = (shift == SHIFT_LATE);

  assert_mutex_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(early_o && late_o));
  assert_zero_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_o |-> (!early_o && !late_o));
  assert_bypass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> (!early_o && !late_o));
  assert_early_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |-> (tap_earlier && !tap_later && code_o));
  assert_late_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_o |-> (tap_later && !tap_earlier && code_o));
  assert_symmetric_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_earlier && tap_later) |-> (!early_o && !late_o));
  assert_isolated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tap_earlier && !tap_later) |-> (!early_o && !late_o));
endmodule

// File: tb/precomp_flagger_test.sv
module precomp_flagger_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, bit_in = 1'b0, byp = 1'b0;
  logic code, early, late;
  logic [4:0] model = '0;   // [0] newest, [4] oldest
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  precomp_flagger uut (
    .clk_i(clk), .rst_ni(rst_n), .code_en_i(en), .code_bit_i(bit_in),
    .bypass_i(byp), .code_o(code), .early_o(early), .late_o(late)
  );

  function automatic logic [2:0] expect_out(logic [4:0] w, logic b);
    logic e, l;
    e = !b && w[2] && w[4] && !w[0];
    l = !b && w[2] && !w[4] && w[0];
    return {w[2], e, l};
  endfunction

  function automatic string req_of(logic [4:0] w, logic b, logic hold);
    if (b) return "R8";
    if (hold) return "R2";
    if (!w[2]) return "R3";
    if (!w[4] && !w[0]) return "R4";
    if (w[4] && w[0]) return "R5";
    if (w[4]) return "R6";
    return "R7";
  endfunction

  task automatic check(string req);
    logic [2:0] exp_v;
    exp_v = expect_out(model, byp);
    checks++;
    if ({code, early, late} !== exp_v) begin
      errors++;
      $display("FAIL %s code/early/late actual=%b expected=%b window=%b", req,
               {code, early, late}, exp_v, model);
    end
    if (early && late) begin
      checks++; errors++;
      $display("FAIL R9 early/late actual=11 expected=not both");
    end
  endtask

  // drive after negedge, check, then commit on posedge
  task automatic step(logic e, logic b, logic bp);
    @(negedge clk);
    en = e; bit_in = b; byp = bp;
    #1 check(req_of(model, bp, !e));
    @(posedge clk);
    if (e) model = {model[3:0], b};
  endtask

  task automatic push5(logic [4:0] pat);  // pat[4] written first
    for (int i = 4; i >= 0; i--) step(1'b1, pat[i], 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    push5(5'b00100); step(1'b0, 1'b0, 1'b0);  // R4
    push5(5'b10101); step(1'b0, 1'b0, 1'b0);  // R5
    push5(5'b10100); step(1'b0, 1'b0, 1'b0);  // R6
    step(1'b0, 1'b1, 1'b1);                   // R8 bypass while frozen
    step(1'b0, 1'b0, 1'b0);                   // R6 returns
    push5(5'b00101); step(1'b0, 1'b1, 1'b0);  // R7
    step(1'b0, 1'b0, 1'b1);                   // R8
    push5(5'b11011); step(1'b0, 1'b0, 1'b0);  // R3

    for (int n = 0; n < 3000; n++)
      step(($urandom % 4) != 0, $urandom % 2, ($urandom % 8) == 0);

    rst_n = 1'b0;
    #1;
    model = '0;
    check("R1");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule